// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and presents one winner to a processor as a priority level plus a vector number. Software reaches it through a small memory-mapped register bus with byte offsets. Through that bus it programs a priority byte for each source, masks or unmasks sources, raises interrupts from software through a force register, and reads back the vector that is currently being presented.

A source takes part in arbitration only after software gives it a nonzero priority byte, and only while its mask bit is clear. Among the sources that take part, the largest priority byte wins. On a tie, the higher source index wins. Two single-byte shortcut registers set or clear one mask bit by index, or every mask bit at once. The level and vector outputs are registered, and they follow the internal state with one cycle of delay.

Top module: `prio_vec_intc`

## Requirements
- R1: A source n is active only when (pending[n] OR force[n]) is 1, its priority byte is nonzero and mask[n] is 0; inactive sources never affect the outputs.
- R2: pending[n] follows irqIn[n], being sampled at each clock edge; pending reads back at offsets 0x00 (bits 63:32) and 0x04 (bits 31:0), and bus writes to those two offsets change nothing.
- R3: The priority byte of source n is written and read at offset 0x40+n (data bits 7:0, read zero-extended); writing 0 removes the source from arbitration and any nonzero value admits it.
- R4: Among active sources the largest priority byte wins; on equal bytes the higher source index wins.
- R5: With a winner n at priority p, irqLevel is p and irqVector is 64+n; with no active source, irqLevel is 0 and irqVector is 24; a read of offset 0xE0 returns irqVector zero-extended.
- R6: The mask reads and writes as two 32-bit halves, bits 63:32 at 0x08 and bits 31:0 at 0x0C; the force register does the same at 0x10 (bits 63:32) and 0x14 (bits 31:0).
- R7: A write to 0x1C sets every mask bit when data bit 6 is 1; otherwise it sets only the mask bit indexed by data bits 5:0.
- R8: A write to 0x1D clears every mask bit when data bit 6 is 1; otherwise it clears only the mask bit indexed by data bits 5:0.
- R9: After reset the mask is all ones, pending, force and every priority byte are zero, irqLevel is 0 and irqVector is 24.
- R10: Reads of 0xE1 to 0xE7 and of any other unmapped offset return 0, and writes to unmapped offsets change no state.
- R11: A register write or a sampled input change shows on irqLevel and irqVector exactly one clock edge after the edge that updated the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 64 | Level-sensitive interrupt inputs, one per source |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busRdEn | input | 1 | Read enable; read data is 0 when low |
| busAddr | input | 8 | Byte offset of the access |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, combinational from the current state |
| irqLevel | output | 8 | Priority of the winning source, 0 when idle |
| irqVector | output | 8 | Vector of the winning source, 24 when idle |

## Verification
A write or input sample updates the state registers at one edge, and the level and vector outputs follow at the next edge, so a change reaches the outputs two edges after the stimulus is driven. Bus writes in the bench return at the falling edge after the state edge. The outputs are first checked there to confirm they still hold the old values, and then checked again one falling edge later against a model that the bench keeps. Read data is combinational, so each read is sampled shortly after the address is driven in the low phase. For interrupt inputs, the bench waits two falling edges before it compares.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned NUM_SRC  = 64;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned HALF_W   = NUM_SRC / 2;

  localparam logic [ADDR_W-1:0] OFF_PEND_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_FORCE_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FORCE_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MSET     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_MCLR     = 8'h1D;
  localparam logic [ADDR_W-1:0] OFF_ACK      = 8'hE0;
  localparam logic [1:0]        PRIO_REGION  = 2'b01;
  localparam int unsigned       ALL_BIT      = 6;

  typedef enum logic [3:0] {
    RD_ZERO, RD_PEND_HI, RD_PEND_LO, RD_MASK_HI, RD_MASK_LO,
    RD_FORCE_HI, RD_FORCE_LO, RD_PRIO, RD_VECTOR
  } rdSel_e;

  typedef struct packed {
    logic              maskHiWr;
    logic              maskLoWr;
    logic              forceHiWr;
    logic              forceLoWr;
    logic              maskSet;
    logic              maskClr;
    logic              maskAll;
    logic              prioWr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wData;
  } ctrlStrobe_t;
endpackage

// File: rtl/pvic_ctrl.sv
module pvic_ctrl
  import pvic_pkg::*;
(
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output ctrlStrobe_t       strobe,
  output rdSel_e            rdSel,
  output logic [IDX_W-1:0]  rdIdx
);
  logic inPrioRegion;
  assign inPrioRegion = (busAddr[ADDR_W-1 -: 2] == PRIO_REGION);
  assign rdIdx = busAddr[IDX_W-1:0];

  always_comb begin
    strobe = '0;
    strobe.wData   = busWData;
    strobe.maskAll = busWData[ALL_BIT];
    strobe.idx     = busWData[IDX_W-1:0];
    if (busWrEn) begin
      if (inPrioRegion) begin
        strobe.prioWr = 1'b1;
        strobe.idx    = busAddr[IDX_W-1:0];
      end else begin
        case (busAddr)
          OFF_MASK_HI:  strobe.maskHiWr  = 1'b1;
          OFF_MASK_LO:  strobe.maskLoWr  = 1'b1;
          OFF_FORCE_HI: strobe.forceHiWr = 1'b1;
          OFF_FORCE_LO: strobe.forceLoWr = 1'b1;
          OFF_MSET:     strobe.maskSet   = 1'b1;
          OFF_MCLR:     strobe.maskClr   = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (busRdEn) begin
      if (inPrioRegion) rdSel = RD_PRIO;
      else begin
        case (busAddr)
          OFF_PEND_HI:  rdSel = RD_PEND_HI;
          OFF_PEND_LO:  rdSel = RD_PEND_LO;
          OFF_MASK_HI:  rdSel = RD_MASK_HI;
          OFF_MASK_LO:  rdSel = RD_MASK_LO;
          OFF_FORCE_HI: rdSel = RD_FORCE_HI;
          OFF_FORCE_LO: rdSel = RD_FORCE_LO;
          OFF_ACK:      rdSel = RD_VECTOR;
          default:      rdSel = RD_ZERO;
        endcase
      end
    end
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        activeVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic [IDX_W-1:0]          winIdx,
  output logic [PRIO_W-1:0]         winLevel,
  output logic                      anyActive
);
  // Ascending scan with >= lets a later (higher-numbered) source take a tie.
  always_comb begin
    winIdx    = '0;
    winLevel  = '0;
    anyActive = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (activeVec[i] && (prioFlat[i*PRIO_W +: PRIO_W] >= winLevel)) begin
        winLevel  = prioFlat[i*PRIO_W +: PRIO_W];
        winIdx    = IDX_W'(i);
        anyActive = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pvic_datapath.sv
module pvic_datapath
  import pvic_pkg::*;
#(
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_IDLE = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  ctrlStrobe_t        strobe,
  input  rdSel_e             rdSel,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DATA_W-1:0]  rdData,
  output logic [PRIO_W-1:0]  levelQ,
  output logic [VEC_W-1:0]   vectorQ
);
  logic [NUM_SRC-1:0]        pendQ, maskQ, forceQ, enBits, activeVec;
  logic [PRIO_W-1:0]         prioQ [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic [IDX_W-1:0]          winIdx;
  logic [PRIO_W-1:0]         winLevel;
  logic                      anyActive;

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= irqIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1;
    end else begin
      if (strobe.maskHiWr) maskQ[NUM_SRC-1:HALF_W] <= strobe.wData;
      if (strobe.maskLoWr) maskQ[HALF_W-1:0]       <= strobe.wData;
      if (strobe.maskSet) begin
        if (strobe.maskAll) maskQ <= '1;
        else                maskQ[strobe.idx] <= 1'b1;
      end
      if (strobe.maskClr) begin
        if (strobe.maskAll) maskQ <= '0;
        else                maskQ[strobe.idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceQ <= '0;
    end else begin
      if (strobe.forceHiWr) forceQ[NUM_SRC-1:HALF_W] <= strobe.wData;
      if (strobe.forceLoWr) forceQ[HALF_W-1:0]       <= strobe.wData;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rstN) prioQ[g] <= '0;
      else if (strobe.prioWr && (strobe.idx == IDX_W'(g)))
        prioQ[g] <= strobe.wData[PRIO_W-1:0];
    end
    assign enBits[g] = |prioQ[g];
    assign prioFlat[g*PRIO_W +: PRIO_W] = prioQ[g];
  end

  assign activeVec = (pendQ | forceQ) & enBits & ~maskQ;

  pvic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) uArb (
    .activeVec(activeVec),
    .prioFlat (prioFlat),
    .winIdx   (winIdx),
    .winLevel (winLevel),
    .anyActive(anyActive)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ  <= '0;
      vectorQ <= VEC_W'(VEC_IDLE);
    end else begin
      levelQ  <= anyActive ? winLevel : '0;
      vectorQ <= anyActive ? VEC_W'(VEC_BASE) + VEC_W'(winIdx) : VEC_W'(VEC_IDLE);
    end
  end

  always_comb begin
    case (rdSel)
      RD_PEND_HI:  rdData = pendQ[NUM_SRC-1:HALF_W];
      RD_PEND_LO:  rdData = pendQ[HALF_W-1:0];
      RD_MASK_HI:  rdData = maskQ[NUM_SRC-1:HALF_W];
      RD_MASK_LO:  rdData = maskQ[HALF_W-1:0];
      RD_FORCE_HI: rdData = forceQ[NUM_SRC-1:HALF_W];
      RD_FORCE_LO: rdData = forceQ[HALF_W-1:0];
      RD_PRIO:     rdData = DATA_W'(prioQ[rdIdx]);
      RD_VECTOR:   rdData = DATA_W'(vectorQ);
      default:     rdData = '0;
    endcase
  end

  // R7: set-all shortcut leaves every mask bit high
  p_mask_set_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskSet && strobe.maskAll) |=> (maskQ == '1));
  // R8: clear-all shortcut leaves every mask bit low
  p_mask_clr_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskClr && strobe.maskAll) |=> (maskQ == '0));
  // R3: a nonzero priority write admits the source
  p_prio_admit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.prioWr && (strobe.wData[PRIO_W-1:0] != '0)) |=>
      ((enBits >> $past(strobe.idx)) & NUM_SRC'(1)) != '0);
  // R5: idle level and idle vector always appear together
  p_idle_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ == '0) == (vectorQ == VEC_W'(VEC_IDLE)));
  // R1/R4: a presented winner was active on the previous cycle
  p_winner_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ != '0) |->
      (($past(activeVec) >> (vectorQ - VEC_W'(VEC_BASE))) & NUM_SRC'(1)) != '0);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_IDLE = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  output logic [PRIO_W-1:0]  irqLevel,
  output logic [VEC_W-1:0]   irqVector
);
  ctrlStrobe_t      strobe;
  rdSel_e           rdSel;
  logic [IDX_W-1:0] rdIdx;

  pvic_ctrl uCtrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .busWData(busWData),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .rdIdx   (rdIdx)
  );

  pvic_datapath #(
    .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_IDLE(VEC_IDLE)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .strobe (strobe),
    .rdSel  (rdSel),
    .rdIdx  (rdIdx),
    .rdData (busRData),
    .levelQ (irqLevel),
    .vectorQ(irqVector)
  );
endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [7:0]  irqLevel, irqVector;

  int testsRun = 0, testsFailed = 0;
  bit done = 1'b0;

  logic [63:0] mPend, mMask, mForce;
  logic [7:0]  mPrio [64];

  always #5 clk = ~clk;

  prio_vec_intc dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .irqLevel(irqLevel), .irqVector(irqVector)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] expectOut();
    logic [7:0] bestL = 0;
    int bestI = 64;
    for (int i = 0; i < 64; i++)
      if ((mPend[i] | mForce[i]) && mPrio[i] != 0 && !mMask[i] && mPrio[i] >= bestL) begin
        bestL = mPrio[i];
        bestI = i;
      end
    return {bestL, (bestI == 64) ? 8'd24 : 8'(64 + bestI)};
  endfunction

  task automatic modelWr(logic [7:0] a, logic [31:0] d);
    if (a[7:6] == 2'b01) mPrio[a[5:0]] = d[7:0];
    else case (a)
      8'h08: mMask[63:32] = d;
      8'h0C: mMask[31:0] = d;
      8'h10: mForce[63:32] = d;
      8'h14: mForce[31:0] = d;
      8'h1C: if (d[6]) mMask = '1; else mMask[d[5:0]] = 1'b1;
      8'h1D: if (d[6]) mMask = '0; else mMask[d[5:0]] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWr(a, d);
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRData;
    busRdEn = 1'b0;
  endtask

  task automatic setIrq(logic [63:0] v);
    @(negedge clk);
    irqIn = v;
    mPend = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chkOut(string tag);
    logic [15:0] e = expectOut();
    logic [31:0] d;
    check({tag, " R5 level"}, 32'(irqLevel), 32'(e[15:8]));
    check({tag, " R5 vector"}, 32'(irqVector), 32'(e[7:0]));
    busRd(8'hE0, d);
    check({tag, " R5 ack read"}, d, 32'(e[7:0]));
  endtask

  // Writes, checks the one-edge lag (R11), then the settled outputs.
  task automatic wrChk(string tag, logic [7:0] a, logic [31:0] d);
    logic [15:0] prev = expectOut();
    busWr(a, d);
    check({tag, " R11 lag"}, 32'({irqLevel, irqVector}), 32'(prev));
    @(negedge clk);
    chkOut(tag);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRd(8'h08, d); check("R9 mask hi", d, 32'hFFFF_FFFF);
    busRd(8'h0C, d); check("R9 mask lo", d, 32'hFFFF_FFFF);
    busRd(8'h04, d); check("R9 pend lo", d, 0);
    busRd(8'h14, d); check("R9 force lo", d, 0);
    busRd(8'h7F, d); check("R9 prio 63", d, 0);
    check("R9 level", 32'(irqLevel), 0);
    check("R9 vector", 32'(irqVector), 24);
  endtask

  task automatic testPending();
    logic [31:0] d;
    setIrq(64'h0000_0001_0000_0020);
    busRd(8'h04, d); check("R2 pend lo", d, 32'h20);
    busRd(8'h00, d); check("R2 pend hi", d, 32'h1);
    chkOut("R1 not enabled");
    busWr(8'h04, 32'h0); busWr(8'h00, 32'h0);
    busRd(8'h04, d); check("R2 pend write ignored", d, 32'h20);
    setIrq(64'h0);
    busRd(8'h04, d); check("R2 pend follows input", d, 0);
  endtask

  task automatic testEnable();
    logic [31:0] d;
    wrChk("R3 prio5", 8'h45, 32'h3);
    busRd(8'h45, d); check("R3 prio readback", d, 32'h3);
    wrChk("R8 clr one", 8'h1D, 32'h05);
    busRd(8'h0C, d); check("R8 mask lo", d, 32'hFFFF_FFDF);
    setIrq(64'h20);
    chkOut("R11 input path");
    check("R5 vector 69", 32'(irqVector), 69);
    wrChk("R7 set one", 8'h1C, 32'h05);
    check("R1 masked idle", 32'(irqVector), 24);
  endtask

  task automatic testArb();
    busWr(8'h4A, 5); busWr(8'h54, 5); busWr(8'h43, 7);
    wrChk("R8 clr all", 8'h1D, 32'h40);
    setIrq(64'h0010_0400);
    chkOut("R4 tie");
    check("R4 tie higher index", 32'(irqVector), 84);
    setIrq(64'h0010_0408);
    chkOut("R4 higher prio");
    check("R4 src3 wins", 32'(irqVector), 67);
    wrChk("R3 disable src3", 8'h43, 0);
    check("R3 back to src20", 32'(irqVector), 84);
  endtask

  task automatic testForce();
    logic [31:0] d;
    busWr(8'h68, 9);
    wrChk("R6 force hi", 8'h10, 32'h100);
    check("R6 forced vector", 32'(irqVector), 104);
    busRd(8'h10, d); check("R6 force readback", d, 32'h100);
    wrChk("R6 mask hi", 8'h08, 32'h100);
    busRd(8'h08, d); check("R6 mask hi readback", d, 32'h100);
    wrChk("R7 set all idx", 8'h1C, 32'h45);
    busRd(8'h0C, d); check("R7 all set lo", d, 32'hFFFF_FFFF);
    busRd(8'h08, d); check("R7 all set hi", d, 32'hFFFF_FFFF);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    wrChk("R8 clr all again", 8'h1D, 32'h40);
    busRd(8'hE3, d); check("R10 read E3", d, 0);
    busRd(8'hE7, d); check("R10 read E7", d, 0);
    busRd(8'h18, d); check("R10 read 18", d, 0);
    wrChk("R10 write 20", 8'h20, 32'hFFFF_FFFF);
    wrChk("R10 write E0", 8'hE0, 32'hFFFF_FFFF);
    busRd(8'h0C, d); check("R10 mask kept", d, 0);
    busRd(8'h14, d); check("R10 force kept", d, 0);
  endtask

  task automatic testSweep();
    for (int k = 0; k < 40; k++) begin
      logic [5:0] s = 6'($urandom);
      busWr({2'b01, s}, 32'($urandom_range(0, 4)));
      if (k % 3 == 0) busWr(8'h1C, 32'($urandom_range(0, 63)));
      setIrq({$urandom, $urandom});
      chkOut("R4 sweep");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog R11 got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    mPend = '0; mMask = '1; mForce = '0;
    for (int i = 0; i < 64; i++) mPrio[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPending();
    testEnable();
    testArb();
    testForce();
    testUnmapped();
    testSweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule